// File: doc/BRIEF.md
# Pad Wake-Up Event Detector

This block watches the input level of a single pad and turns it into a wake-up request. The pad level is asynchronous, so it is first brought into the always-on clock domain through a chain of flip-flops. A 3-bit mode field then selects how the synchronized level is judged. The pad can be ignored, it can wake on a held low level or a held high level, or it can wake on a rising or a falling transition.

Each detected event raises a one-cycle-registered request output and sets a sticky status flag. The flag holds until software pulses the clear strobe. An event that lands in the same cycle as the clear keeps the flag set. When the mode field changes, edge sensing is blanked for that one cycle. This stops the level history built up under the old mode from being reported as a new edge.

Top module: `pwd_wake_top`

## Requirements
- R1: While reset is low at a clock edge, and after that edge, both `wake_req` and `wake_flag` read 0.
- R2: Mode codes 0, 5, 6 and 7 never produce a wake event, whatever the pad does.
- R3: In mode 1 (low level), `wake_req` is 1 in every cycle whose pad level, taken three clock edges earlier, was 0. The delay is two synchronizer flops plus the output register.
- R4: In mode 2 (high level), `wake_req` is 1 in every cycle whose pad level, taken three clock edges earlier, was 1.
- R5: In mode 3 (rising edge), a pad change from 0 to 1 gives a `wake_req` pulse exactly one cycle long, three edges after the change. A pad held high gives no further pulses.
- R6: In mode 4 (falling edge), a pad change from 1 to 0 gives a one-cycle `wake_req` pulse, three edges after the change.
- R7: `wake_flag` is set by every event and stays at 1 while `clr` is low.
- R8: A `clr` pulse with no event in that cycle drops `wake_flag` to 0 at the next edge. If an event occurs in the same cycle as `clr`, `wake_flag` remains 1.
- R9: In any cycle where `mode` differs from its value in the previous cycle, edge detection (modes 3 and 4) is suppressed. Level modes are not affected. After reset the previous mode counts as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pad_in | input | 1 | Asynchronous pad level |
| mode | input | 3 | Detection mode: 0 off, 1 low, 2 high, 3 rise, 4 fall, 5-7 off |
| clr | input | 1 | Clear strobe for the sticky flag |
| wake_req | output | 1 | Registered wake event, one per detected cycle |
| wake_flag | output | 1 | Sticky wake status |

## Verification
The assertions assume that `mode` and `clr` are synchronous to `clk` and change only between edges. `pad_in` may change in any cycle, because only the synchronized copy is checked. The pulse-width property relies on `mode` being sampled only at clock edges. The bench therefore drives every input on the falling edge. It sweeps every 8-cycle pad pattern under all eight mode codes, with a clear at the start of each pattern. It then applies a pseudo-random mix of pad toggles, mode changes and clears.

// File: rtl/pwd_pkg.sv
// Package: shared widths and mode codes for the pad wake-up detector.
// Assumes the mode field encoding is fixed; unused codes decode as off.
package pwd_pkg;
    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] WK_OFF  = 3'd0;
    localparam logic [MODE_W-1:0] WK_LOW  = 3'd1;
    localparam logic [MODE_W-1:0] WK_HIGH = 3'd2;
    localparam logic [MODE_W-1:0] WK_RISE = 3'd3;
    localparam logic [MODE_W-1:0] WK_FALL = 3'd4;
endpackage

// File: rtl/pwd_sync.sv
// Module: multi-flop level synchronizer.
// Brings the asynchronous pad level into the clk domain. Assumes STAGES >= 2.
// The chain resets to 0, so the pad reads as low until the chain has filled.
module pwd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the pad level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pwd_detect.sv
// Module: level/edge event decoder.
// Judges the synchronized level against the selected mode. Edges are taken
// against the previous synchronized sample and are blanked in any cycle where
// the mode differs from the previous cycle's mode. Codes above 4 act as off.
module pwd_detect
    import pwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic [MODE_W-1:0] mode,
    output logic              evt
);
    logic              prev_q;
    logic [MODE_W-1:0] mode_q;
    logic              mode_same;
    logic              rise_seen;
    logic              fall_seen;

    // Keep last synchronized level and last mode as detection history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            mode_q <= WK_OFF;
        end else begin
            prev_q <= lvl;
            mode_q <= mode;
        end
    end

    assign mode_same = (mode == mode_q);
    assign rise_seen = lvl & ~prev_q;
    assign fall_seen = ~lvl & prev_q;

    // Decode the event for the current mode.
    always_comb begin
        case (mode)
            WK_LOW:  evt = ~lvl;
            WK_HIGH: evt = lvl;
            WK_RISE: evt = rise_seen & mode_same;
            WK_FALL: evt = fall_seen & mode_same;
            default: evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwd_flag.sv
// Module: registered request and sticky status flag.
// The flag sets on an event and clears on the strobe; an event in the
// clearing cycle takes priority.
module pwd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic req,
    output logic flag
);
    // Register the event and update the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req  <= 1'b0;
            flag <= 1'b0;
        end else begin
            req  <= evt;
            flag <= evt | (flag & ~clr);
        end
    end
endmodule

// File: rtl/pwd_wake_top.sv
// Module: pad wake-up event detector top.
// Chains synchronizer, decoder and flag logic for one pad. Assumes mode and
// clr are synchronous to clk; pad_in may be fully asynchronous.
module pwd_wake_top
    import pwd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pad_in,
    input  logic [MODE_W-1:0] mode,
    input  logic              clr,
    output logic              wake_req,
    output logic              wake_flag
);
    logic pad_sync;
    logic pad_evt;

    pwd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (pad_sync)
    );

    pwd_detect u_detect (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (pad_sync),
        .mode (mode),
        .evt  (pad_evt)
    );

    pwd_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (pad_evt),
        .clr  (clr),
        .req  (wake_req),
        .flag (wake_flag)
    );
endmodule

// File: rtl/pwd_wake_chk.sv
// Module: property checker for the wake-up detector, bound to the top.
// Assumes inputs change only between clock edges.
module pwd_wake_chk
    import pwd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode,
    input logic              clr,
    input logic              lvl,
    input logic              wake_req,
    input logic              wake_flag
);
    // R1: outputs are low after a reset edge.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!wake_req && !wake_flag));

    // R2: off codes never yield a request.
    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WK_OFF || mode > WK_FALL) |=> !wake_req);

    // R3: low level in low mode yields a request.
    assert_low_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WK_LOW && !lvl) |=> wake_req);

    // R4: high level in high mode yields a request.
    assert_high_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WK_HIGH && lvl) |=> wake_req);

    // R5 and R6: edge requests are single-cycle pulses.
    assert_edge_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == WK_RISE || mode == WK_FALL) && wake_req) |=> !wake_req);

    // R7: a request always comes with the flag set.
    assert_flag_with_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> wake_flag);

    // R7: the flag holds without a clear.
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && !clr) |=> wake_flag);

    // R8: after a clear, the flag equals only the fresh event.
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (wake_flag == wake_req));

    // R9: a mode change into an edge mode blanks that cycle.
    assert_mode_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == WK_RISE || mode == WK_FALL) && mode != $past(mode)) |=> !wake_req);
endmodule

bind pwd_wake_top pwd_wake_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .clr      (clr),
    .lvl      (pad_sync),
    .wake_req (wake_req),
    .wake_flag(wake_flag)
);

// File: tb/pwd_wake_top_test.sv
module pwd_wake_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pad_in = 1'b0;
    logic [2:0] mode = 3'd0;
    logic       clr = 1'b0;
    logic       wake_req;
    logic       wake_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    // Requirement-level model: pad seen two edges late, output one edge later.
    logic m_s1 = 0, m_s2 = 0, m_prev = 0, m_req = 0, m_flag = 0;
    logic [2:0] m_modeq = 0;
    logic m_ev;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    pwd_wake_top uut (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .mode(mode),
        .clr(clr), .wake_req(wake_req), .wake_flag(wake_flag)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_req <= 0; m_flag <= 0; m_modeq <= 0;
        end else begin
            m_ev = (mode == 3'd1 && !m_s2) || (mode == 3'd2 && m_s2)
                || (mode == 3'd3 && m_s2 && !m_prev && mode == m_modeq)
                || (mode == 3'd4 && !m_s2 && m_prev && mode == m_modeq);
            m_req  <= m_ev;
            m_flag <= m_ev || (m_flag && !clr);
            m_s1 <= pad_in; m_s2 <= m_s1; m_prev <= m_s2; m_modeq <= mode;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // At the falling edge: compare against model, then drive next inputs.
    task automatic step(input logic p, input logic [2:0] m, input logic c);
        @(negedge clk);
        check(cur_tag, wake_req, m_req, "wake_req");
        check(cur_tag, wake_flag, m_flag, "wake_flag");
        if ((m == 3'd3 || m == 3'd4) && m != mode) cur_tag = "R9";
        else if (c) cur_tag = "R8";
        else case (m)
            3'd1: cur_tag = "R3";
            3'd2: cur_tag = "R4";
            3'd3: cur_tag = "R5";
            3'd4: cur_tag = "R6";
            default: cur_tag = "R2";
        endcase
        if (m_flag && !c && cur_tag != "R9") cur_tag = {cur_tag, "/R7"};
        pad_in = p; mode = m; clr = c;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] lfsr;
        logic [2:0]  rmode;
        repeat (3) @(negedge clk);
        check("R1", wake_req, 1'b0, "reset wake_req");
        check("R1", wake_flag, 1'b0, "reset wake_flag");
        rst_n = 1'b1;

        // R5 directed: rising pulse exactly three edges after change, one cycle wide.
        step(0, 3'd3, 0); step(0, 3'd3, 0); step(0, 3'd3, 0);
        step(1, 3'd3, 0);
        @(negedge clk); check("R5", wake_req, 1'b0, "edge+1");
        @(negedge clk); check("R5", wake_req, 1'b0, "edge+2");
        @(negedge clk); check("R5", wake_req, 1'b1, "edge+3");
        @(negedge clk); check("R5", wake_req, 1'b0, "edge+4");
        check("R7", wake_flag, 1'b1, "flag held");
        step(1, 3'd3, 1);
        @(negedge clk); check("R8", wake_flag, 1'b0, "cleared");
        step(1, 3'd3, 0);

        // Sweep every 8-cycle pad pattern under every mode code.
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 256; p++) begin
                for (int b = 0; b < 8; b++)
                    step(p[b], m[2:0], b == 0);
            end
        end

        // Pseudo-random mix of pad, mode changes and clears.
        lfsr = 16'hACE1;
        rmode = 3'd0;
        for (int i = 0; i < 20000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[7:5] == 3'd0) rmode = lfsr[10:8];
            step(lfsr[0] ^ lfsr[3], rmode, lfsr[12:11] == 2'd0);
        end
        step(0, 3'd0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule